// File: doc/BRIEF.md
# Serial Sampling Converter Interface Model

This block stands in for the digital side of a small serial-output sampling converter, so that a host controller can be exercised without the real part. The host drives a low-active select and a serial clock. The block takes a parallel sample word from a register or stimulus port. It returns a 16-slot serial frame on a data pin with a separate output enable. A hold indicator shows when the notional input is frozen.

Both host inputs are oversampled on a fast system clock, and edges are found by comparing against the previous sample. Every output changes one system clock after the host edge that causes it. The resolution parameter picks 8, 10 or 12 bits. The conversion length is the resolution plus four serial clocks. For 10 and 12 bits the hold ends on the serial rising edge after the 13th falling edge. For 8 bits it ends after the 11th.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, when a falling select is accepted, the next system clock shows sdo_oe=1 and hold=1, and the sample present at that edge is captured for the frame.
- R2: Frame slot k (k=0..15) is driven on sdo after k serial falling edges. Slots 0..3 are 0. Slots 4..4+RES-1 carry the captured sample, MSB first. The remaining slots are 0.
- R3: sdo does not change on a serial rising edge. It still shows the slot set up by the preceding falling edge.
- R4: With RES of 10 or 12, hold falls on the first serial rising edge that comes after at least 13 falling edges of the frame.
- R5: With RES of 8, hold falls on the first serial rising edge that comes after at least 11 falling edges.
- R6: The 16th serial falling edge clears sdo_oe. Further falling edges while select stays low change nothing.
- R7: A select rise before RES+4 falling edges abandons the frame. sdo_oe and hold drop on the next system clock, and no conv_done is ever raised for that frame.
- R8: A select rise after RES+4 but before 16 falling edges also clears sdo_oe at once. The frame keeps the conv_done it already gave.
- R9: conv_done is high for exactly one system clock, right after the (RES+4)-th falling edge of an accepted frame.
- R10: A select fall is accepted only if select was sampled high on at least QUIET_CYC system clocks before it. An earlier fall leaves sdo_oe and hold low for the whole low period and pulses early_sel for one clock.
- R11: sdo is 0 whenever sdo_oe is 0.
- R12: Under reset sdo, sdo_oe, hold, conv_done and early_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host signals |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Host select, active low |
| sclk | input | 1 | Host serial clock |
| sample | input | RES | Parallel word converted in the next frame |
| sdo | output | 1 | Serial data, valid while sdo_oe is high |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| hold | output | 1 | High while the input is held |
| conv_done | output | 1 | One-clock pulse when a conversion completes |
| early_sel | output | 1 | One-clock pulse when a select fall is rejected |

## Verification
The hardest situations to reach are the select rise that lands exactly on the conversion count, and a select fall that arrives one system clock before the quiet period ends. Random frames use falling-edge counts from 0 to 18 and quiet gaps that straddle the threshold. Directed frames place the rise at 11, 12, 13, 14 and 16 edges, where the three resolutions differ. Instances at 8, 10 and 12 bits share one stimulus stream, so a single frame covers several boundaries at the same time.

// File: rtl/adc_serial_slave.sv
module adc_serial_slave #(
  parameter int RES       = 12,
  parameter int QUIET_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [RES-1:0] sample,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           hold,
  output logic           conv_done,
  output logic           early_sel
);
  localparam int FRAME = 16;
  localparam int CONV  = RES + 4;
  localparam int TRACK = (RES == 8) ? 11 : 13;
  localparam int PAD   = 12 - RES;
  localparam int QW    = $clog2(QUIET_CYC + 1);

  logic          cs_q, sclk_q, act;
  logic [4:0]    nfall;
  logic [15:0]   shreg;
  logic [QW-1:0] quiet;
  logic [15:0]   load_word;

  wire cs_fall = cs_q & ~cs_n;
  wire cs_rise = ~cs_q & cs_n;
  wire sc_fall = sclk_q & ~sclk;
  wire sc_rise = ~sclk_q & sclk;
  wire ready   = quiet >= QW'(QUIET_CYC);

  assign load_word = 16'(sample) << PAD;
  assign sdo       = sdo_oe & shreg[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      act       <= 1'b0;
      nfall     <= '0;
      shreg     <= '0;
      quiet     <= QW'(QUIET_CYC);
      sdo_oe    <= 1'b0;
      hold      <= 1'b0;
      conv_done <= 1'b0;
      early_sel <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      sclk_q    <= sclk;
      conv_done <= 1'b0;
      early_sel <= 1'b0;

      if (cs_n) quiet <= ready ? quiet : quiet + 1'b1;
      else      quiet <= '0;

      if (cs_fall) begin
        if (ready) begin
          act    <= 1'b1;
          nfall  <= '0;
          shreg  <= load_word;
          sdo_oe <= 1'b1;
          hold   <= 1'b1;
        end else begin
          early_sel <= 1'b1;
        end
      end else if (cs_rise) begin
        act    <= 1'b0;
        sdo_oe <= 1'b0;
        hold   <= 1'b0;
      end else if (act) begin
        if (sc_fall && nfall != 5'(FRAME)) begin
          nfall <= nfall + 1'b1;
          shreg <= {shreg[14:0], 1'b0};
          if (nfall == 5'(FRAME - 1)) sdo_oe <= 1'b0;
          if (nfall == 5'(CONV - 1))  conv_done <= 1'b1;
        end
        if (sc_rise && nfall >= 5'(TRACK)) hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo_oe,
  input logic hold,
  input logic conv_done,
  input logic early_sel
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (!$past(cs_n) && hold));

  assert_hold_with_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $rose(sdo_oe));

  assert_deselect_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdo_oe);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  assert_done_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !$past(cs_n));

  assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    early_sel |-> (!sdo_oe && !hold));
endmodule

bind adc_serial_slave adc_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .hold(hold), .conv_done(conv_done), .early_sel(early_sel)
);

// File: tb/sim_adc_serial_slave.sv
`timescale 1ns/1ps
module sim_adc_serial_slave;
  localparam int QC = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [11:0] smp = '0;
  logic [2:0] o_sdo, o_oe, o_hold, o_done, o_err;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_serial_slave #(.RES(12), .QUIET_CYC(QC)) u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(smp), .sdo(o_sdo[0]), .sdo_oe(o_oe[0]), .hold(o_hold[0]), .conv_done(o_done[0]), .early_sel(o_err[0]));
  adc_serial_slave #(.RES(10), .QUIET_CYC(QC)) u1 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(smp[11:2]), .sdo(o_sdo[1]), .sdo_oe(o_oe[1]), .hold(o_hold[1]), .conv_done(o_done[1]), .early_sel(o_err[1]));
  adc_serial_slave #(.RES(8), .QUIET_CYC(QC)) u2 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(smp[11:4]), .sdo(o_sdo[2]), .sdo_oe(o_oe[2]), .hold(o_hold[2]), .conv_done(o_done[2]), .early_sel(o_err[2]));

  function automatic int res_of(int k); return (k == 0) ? 12 : (k == 1) ? 10 : 8; endfunction
  function automatic int conv_of(int k); return res_of(k) + 4; endfunction
  function automatic int trk_of(int k); return (res_of(k) == 8) ? 11 : 13; endfunction
  function automatic int exp_bit(int k, logic [11:0] s, int pos);
    int r = res_of(k);
    logic [11:0] v = s >> (12 - r);
    if (pos < 4 || pos >= 4 + r) return 0;
    return int'(v[r - 1 - (pos - 4)]);
  endfunction

  task automatic check(string req, int k, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s inst%0d actual=%0d expected=%0d t=%0t", req, k, act, exp, $time);
    end
  endtask

  task automatic run_frame(logic [11:0] s, int nf, int gap);
    smp = s; cs_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R1 oe", k, o_oe[k], 1); check("R1 hold", k, o_hold[k], 1);
      check("R2 slot0", k, o_sdo[k], exp_bit(k, s, 0)); check("R9 idle", k, o_done[k], 0);
    end
    smp = ~s;
    for (int i = 1; i <= nf; i++) begin
      sclk = 1'b1; @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        check(res_of(k) == 8 ? "R5 hold" : "R4 hold", k, o_hold[k], (i - 1 < trk_of(k)) ? 1 : 0);
        check("R3 sdo at rise", k, o_sdo[k], (i - 1 < 16) ? exp_bit(k, s, i - 1) : 0);
      end
      sclk = 1'b0; @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        check("R9 done", k, o_done[k], (i == conv_of(k)) ? 1 : 0);
        check("R6 oe", k, o_oe[k], (i < 16) ? 1 : 0);
        check("R2 R11 sdo", k, o_sdo[k], (i < 16) ? exp_bit(k, s, i) : 0);
      end
      @(negedge clk);
      for (int k = 0; k < 3; k++) check("R9 single", k, o_done[k], 0);
    end
    cs_n = 1'b1; @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(nf < conv_of(k) ? "R7 oe" : "R8 oe", k, o_oe[k], 0);
      check("R7 hold", k, o_hold[k], 0);
      check("R7 no done", k, o_done[k], 0);
      check("R11 sdo", k, o_sdo[k], 0);
    end
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic reject_frame(int gap);
    cs_n = 1'b0; @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R10 flag", k, o_err[k], 1); check("R10 oe", k, o_oe[k], 0); check("R10 hold", k, o_hold[k], 0);
    end
    @(negedge clk);
    for (int k = 0; k < 3; k++) check("R10 pulse", k, o_err[k], 0);
    repeat (4) begin
      sclk = 1'b1; @(negedge clk); sclk = 1'b0; @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        check("R10 off", k, o_oe[k], 0); check("R10 sdo", k, o_sdo[k], 0);
        check("R10 nohold", k, o_hold[k], 0); check("R10 nodone", k, o_done[k], 0);
      end
    end
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R12 oe", k, o_oe[k], 0); check("R12 hold", k, o_hold[k], 0);
      check("R12 sdo", k, o_sdo[k], 0); check("R12 done", k, o_done[k], 0); check("R12 err", k, o_err[k], 0);
    end
    rst_n = 1'b1;
    repeat (QC) @(negedge clk);
    run_frame(12'hA5C, 16, QC);
    run_frame(12'hFFF, 18, QC);
    run_frame(12'h3C1, 11, QC);
    run_frame(12'h800, 12, QC);
    run_frame(12'h001, 13, QC);
    run_frame(12'h5A5, 14, QC);
    run_frame(12'h7E3, 0, QC);
    run_frame(12'h0F0, 16, QC - 1);
    reject_frame(QC);
    run_frame(12'h9B2, 15, QC);
    void'($urandom(32'h5EED1));
    for (int f = 0; f < 60; f++) begin
      int gap = QC - 2 + int'($urandom % 6);
      if (gap < QC) begin
        run_frame(12'($urandom), 16, gap);
        reject_frame(QC + int'($urandom % 3));
      end else begin
        run_frame(12'($urandom), int'($urandom % 19), gap);
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule